// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for one display pipe. Software programs a small bank of 32-bit timing words through a write port: horizontal and vertical totals, blanking windows and sync windows, and a source window size. The block then runs a horizontal pixel counter and a vertical line counter. From these it derives blanking, sync, an active-area enable and a source-window enable, one pixel per clock. Every position is stored as its count minus one, with two 16-bit fields packed into each word.

A control word holds an enable request bit and a separate read-only running status bit. Setting the enable starts a fresh frame from counter position zero. Clearing it lets the current frame finish before the pipe stops. While either bit is set, the timing words are locked against writes, so a frame never sees its geometry change part way through. Register reads are combinational through a separate read address. The block moves no pixel data, so it has no valid/ready stream; all pins are plain control and status.

Top module: `dtg_pipe_timing`

## Requirements
- R1: The register layout is as follows. Address 0 holds horizontal active-1 in bits 15:0 and total-1 in bits 31:16. Address 1 holds horizontal blank start-1 (low half) and blank end-1 (high half). Address 2 holds horizontal sync start-1 (low half) and sync end-1 (high half). Addresses 3, 4 and 5 hold the same three words for the vertical axis. Address 6 holds source height-1 in the low half and source width-1 in the high half. Each of these words reads back exactly as written.
- R2: While running, h_count steps from 0 to horizontal total-1 and wraps to 0. v_count advances by one when h_count wraps, and returns to 0 after the last line, vertical total-1.
- R3: pix_active is high exactly when the pipe is running, h_count <= horizontal active-1 and v_count <= vertical active-1.
- R4: While running, h_blank is high when blank start-1 < h_count <= blank end-1, and v_blank obeys the same rule on v_count.
- R5: While running, h_sync is high when sync start-1 < h_count <= sync end-1, and v_sync obeys the same rule on v_count. Equal start and end give no pulse.
- R6: src_active is high exactly when the pipe is running, h_count <= source width-1 and v_count <= source height-1.
- R7: Address 7 is the control word. Bit 31 is the enable request and reads back as written. Bit 30 reads as the running status, and writing it has no effect. All other bits read 0.
- R8: Writing enable=1 while stopped raises pipe_running after one further clock edge, with both counters at 0, and counting begins on the edge after that.
- R9: Clearing enable lets the current frame run to its last pixel. On the following edge pipe_running falls and both counters return to 0.
- R10: Writes to addresses 0–6 are ignored while the enable bit or the running status is set, and are accepted when both are clear.
- R11: After reset, every register reads 0, pipe_running is 0, and all counters and timing outputs are 0. Whenever the pipe is stopped, the counters and all timing outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| pipe_running | output | 1 | Running status |
| h_count | output | 16 | Horizontal pixel position |
| v_count | output | 16 | Vertical line position |
| pix_active | output | 1 | Active-area enable |
| src_active | output | 1 | Source-window enable |
| h_blank | output | 1 | Horizontal blanking |
| v_blank | output | 1 | Vertical blanking |
| h_sync | output | 1 | Horizontal sync pulse |
| v_sync | output | 1 | Vertical sync pulse |

## Verification
The in-line properties check the following on every cycle:
- the timing words stay frozen while enable or status is set;
- the counters never pass their programmed totals;
- the status rises only under an enable request and falls only after the last pixel of a frame with the request cleared;
- the active enable and the counters are zero whenever the pipe is stopped.

Only the bench's scenarios can show that each output window lands on the right pixel and line for a given programming, since that depends on arithmetic over whole frames. Two distinct geometries are swept over every pixel, including a border where blanking starts after the active area and a zero-width sync. The same scenarios show the one-edge start latency and the drain-to-frame-end stop.

// File: rtl/tg_pkg.sv
package tg_pkg;
  parameter int unsigned TG_FW = 16;
  parameter int unsigned TG_AW = 3;

  typedef enum logic [TG_AW-1:0] {
    SEL_HTIM = 3'd0,
    SEL_HBLK = 3'd1,
    SEL_HSYN = 3'd2,
    SEL_VTIM = 3'd3,
    SEL_VBLK = 3'd4,
    SEL_VSYN = 3'd5,
    SEL_SRC  = 3'd6,
    SEL_CTRL = 3'd7
  } reg_sel_e;

  localparam int unsigned TG_NWORDS = 7;

  typedef struct packed {
    logic [TG_FW-1:0] tot_m1;
    logic [TG_FW-1:0] act_m1;
    logic [TG_FW-1:0] bend_m1;
    logic [TG_FW-1:0] bst_m1;
    logic [TG_FW-1:0] send_m1;
    logic [TG_FW-1:0] sst_m1;
  } axis_cfg_t;
endpackage

// File: rtl/tg_regfile.sv
module tg_regfile
  import tg_pkg::*;
#(
  parameter int unsigned FW = TG_FW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [TG_AW-1:0]     wr_addr,
  input  logic [2*FW-1:0]      wr_data,
  input  logic [TG_AW-1:0]     rd_addr,
  output logic [2*FW-1:0]      rd_data,
  input  logic                 running,
  output logic                 en,
  output axis_cfg_t            hcfg,
  output axis_cfg_t            vcfg,
  output logic [FW-1:0]        src_w_m1,
  output logic [FW-1:0]        src_h_m1
);
  localparam int unsigned DW      = 2 * FW;
  localparam int unsigned EN_BIT  = DW - 1;
  localparam int unsigned RUN_BIT = DW - 2;

  logic            locked;
  logic [DW-1:0]   tword [TG_NWORDS];

  assign locked = en | running;

  // timing words: one register each, frozen while the pipe is live
  for (genvar gi = 0; gi < TG_NWORDS; gi++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && !locked && wr_addr == TG_AW'(gi))
        word_q <= wr_data;
    end
    assign tword[gi] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en <= 1'b0;
    else if (wr_en && wr_addr == SEL_CTRL)
      en <= wr_data[EN_BIT];
  end

  assign hcfg.act_m1  = tword[SEL_HTIM][FW-1:0];
  assign hcfg.tot_m1  = tword[SEL_HTIM][DW-1:FW];
  assign hcfg.bst_m1  = tword[SEL_HBLK][FW-1:0];
  assign hcfg.bend_m1 = tword[SEL_HBLK][DW-1:FW];
  assign hcfg.sst_m1  = tword[SEL_HSYN][FW-1:0];
  assign hcfg.send_m1 = tword[SEL_HSYN][DW-1:FW];
  assign vcfg.act_m1  = tword[SEL_VTIM][FW-1:0];
  assign vcfg.tot_m1  = tword[SEL_VTIM][DW-1:FW];
  assign vcfg.bst_m1  = tword[SEL_VBLK][FW-1:0];
  assign vcfg.bend_m1 = tword[SEL_VBLK][DW-1:FW];
  assign vcfg.sst_m1  = tword[SEL_VSYN][FW-1:0];
  assign vcfg.send_m1 = tword[SEL_VSYN][DW-1:FW];
  assign src_h_m1     = tword[SEL_SRC][FW-1:0];
  assign src_w_m1     = tword[SEL_SRC][DW-1:FW];

  always_comb begin
    rd_data = '0;
    if (rd_addr == SEL_CTRL) begin
      rd_data[EN_BIT]  = en;
      rd_data[RUN_BIT] = running;
    end else begin
      for (int i = 0; i < TG_NWORDS; i++)
        if (rd_addr == TG_AW'(i)) rd_data = tword[i];
    end
  end

  // R10: geometry frozen while enable or status is set
  a_r10_frozen_when_live: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(hcfg) && $stable(vcfg) && $stable(src_w_m1) && $stable(src_h_m1)));

  // R7: enable bit follows a control write
  a_r7_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_CTRL) |=> (en == $past(wr_data[EN_BIT])));
endmodule

// File: rtl/tg_axis_counter.sv
module tg_axis_counter #(
  parameter int unsigned FW = tg_pkg::TG_FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clr,
  input  logic [FW-1:0] limit,
  output logic [FW-1:0] cnt,
  output logic          at_limit
);
  assign at_limit = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (step)
      cnt <= at_limit ? '0 : cnt + 1'b1;
  end

  // R2: position never passes the programmed total
  a_r2_within_total: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);

  // R9: a clear returns the position to zero
  a_r9_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/tg_axis_decode.sv
module tg_axis_decode
  import tg_pkg::*;
(
  input  logic [TG_FW-1:0] cnt,
  input  axis_cfg_t        cfg,
  input  logic [TG_FW-1:0] win_m1,
  output logic             in_act,
  output logic             in_blank,
  output logic             in_sync,
  output logic             in_win
);
  // fields hold position-1: window covers (start-1, end-1]
  assign in_act   = (cnt <= cfg.act_m1);
  assign in_blank = (cnt > cfg.bst_m1) && (cnt <= cfg.bend_m1);
  assign in_sync  = (cnt > cfg.sst_m1) && (cnt <= cfg.send_m1);
  assign in_win   = (cnt <= win_m1);
endmodule

// File: rtl/tg_run_ctrl.sv
module tg_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic frame_end,
  output logic running,
  output logic stop
);
  assign stop = running & ~en & frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      running <= 1'b0;
    else if (!running && en)
      running <= 1'b1;
    else if (stop)
      running <= 1'b0;
  end

  // R8: status only rises under an enable request
  a_r8_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(en));

  // R9: status only falls after the last pixel with enable clear
  a_r9_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(frame_end) && !$past(en)));
endmodule

// File: rtl/dtg_pipe_timing.sv
module dtg_pipe_timing
  import tg_pkg::*;
#(
  parameter int unsigned FW = TG_FW,
  parameter int unsigned AW = TG_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [2*FW-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [2*FW-1:0] rd_data,
  output logic            pipe_running,
  output logic [FW-1:0]   h_count,
  output logic [FW-1:0]   v_count,
  output logic            pix_active,
  output logic            src_active,
  output logic            h_blank,
  output logic            v_blank,
  output logic            h_sync,
  output logic            v_sync
);
  axis_cfg_t     hcfg, vcfg;
  logic [FW-1:0] src_w_m1, src_h_m1;
  logic          en, stop, h_last, v_last;
  logic          h_act, h_blk, h_syn, h_win;
  logic          v_act, v_blk, v_syn, v_win;

  tg_regfile #(.FW(FW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .running(pipe_running), .en(en),
    .hcfg(hcfg), .vcfg(vcfg),
    .src_w_m1(src_w_m1), .src_h_m1(src_h_m1)
  );

  tg_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .en(en),
    .frame_end(h_last & v_last),
    .running(pipe_running), .stop(stop)
  );

  tg_axis_counter #(.FW(FW)) u_hcnt (
    .clk(clk), .rst_n(rst_n),
    .step(pipe_running & ~stop), .clr(stop),
    .limit(hcfg.tot_m1), .cnt(h_count), .at_limit(h_last)
  );

  tg_axis_counter #(.FW(FW)) u_vcnt (
    .clk(clk), .rst_n(rst_n),
    .step(pipe_running & ~stop & h_last), .clr(stop),
    .limit(vcfg.tot_m1), .cnt(v_count), .at_limit(v_last)
  );

  tg_axis_decode u_hdec (
    .cnt(h_count), .cfg(hcfg), .win_m1(src_w_m1),
    .in_act(h_act), .in_blank(h_blk), .in_sync(h_syn), .in_win(h_win)
  );

  tg_axis_decode u_vdec (
    .cnt(v_count), .cfg(vcfg), .win_m1(src_h_m1),
    .in_act(v_act), .in_blank(v_blk), .in_sync(v_syn), .in_win(v_win)
  );

  assign pix_active = pipe_running & h_act & v_act;
  assign src_active = pipe_running & h_win & v_win;
  assign h_blank    = pipe_running & h_blk;
  assign v_blank    = pipe_running & v_blk;
  assign h_sync     = pipe_running & h_syn;
  assign v_sync     = pipe_running & v_syn;

  // R3: active area only while running
  a_r3_active_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    pix_active |-> pipe_running);

  // R11: counters parked at zero while stopped
  a_r11_idle_counters_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_running |-> (h_count == '0 && v_count == '0));
endmodule

// File: tb/tb_dtg_pipe_timing.sv
`timescale 1ns/1ps
module tb_dtg_pipe_timing;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pipe_running, pix_active, src_active, h_blank, v_blank, h_sync, v_sync;
  logic [15:0] h_count, v_count;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  int c_hact, c_htot, c_hbs, c_hbe, c_hss, c_hse;
  int c_vact, c_vtot, c_vbs, c_vbe, c_vss, c_vse, c_srcw, c_srch;

  always #4 clk = ~clk;

  dtg_pipe_timing dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pipe_running(pipe_running),
    .h_count(h_count), .v_count(v_count), .pix_active(pix_active), .src_active(src_active),
    .h_blank(h_blank), .v_blank(v_blank), .h_sync(h_sync), .v_sync(v_sync)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic outs(input bit run_e, input int t);
    int h, v;
    if (!run_e) begin
      chk("R9 running low", pipe_running, 0);
      chk("R11 h idle", h_count, 0);
      chk("R11 v idle", v_count, 0);
      chk("R11 outputs idle", {pix_active, src_active, h_blank, v_blank, h_sync, v_sync}, 0);
    end else begin
      h = t % (c_htot + 1);
      v = (t / (c_htot + 1)) % (c_vtot + 1);
      chk("R8 running high", pipe_running, 1);
      chk("R2 h_count", h_count, h);
      chk("R2 v_count", v_count, v);
      chk("R3 pix_active", pix_active, (h <= c_hact && v <= c_vact));
      chk("R4 h_blank", h_blank, (h > c_hbs && h <= c_hbe));
      chk("R4 v_blank", v_blank, (v > c_vbs && v <= c_vbe));
      chk("R5 h_sync", h_sync, (h > c_hss && h <= c_hse));
      chk("R5 v_sync", v_sync, (v > c_vss && v <= c_vse));
      chk("R6 src_active", src_active, (h <= c_srcw && v <= c_srch));
    end
  endtask

  task automatic cyc(input bit do_chk, input bit run_e, input int t,
                     input bit do_wr, input int addr, input logic [31:0] data);
    @(negedge clk);
    if (do_chk) outs(run_e, t);
    wr_en   = do_wr;
    wr_addr = addr[2:0];
    wr_data = data;
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string tag);
    rd_addr = addr[2:0];
    #1;
    chk(tag, rd_data, exp);
  endtask

  function automatic logic [31:0] pk(input int hi, input int lo);
    return {hi[15:0], lo[15:0]};
  endfunction

  task automatic load_cfg(input int hact, htot, hbs, hbe, hss, hse,
                          input int vact, vtot, vbs, vbe, vss, vse, srcw, srch);
    c_hact = hact; c_htot = htot; c_hbs = hbs; c_hbe = hbe; c_hss = hss; c_hse = hse;
    c_vact = vact; c_vtot = vtot; c_vbs = vbs; c_vbe = vbe; c_vss = vss; c_vse = vse;
    c_srcw = srcw; c_srch = srch;
    cyc(0, 0, 0, 1, 0, pk(htot, hact));
    cyc(0, 0, 0, 1, 1, pk(hbe, hbs));
    cyc(0, 0, 0, 1, 2, pk(hse, hss));
    cyc(0, 0, 0, 1, 3, pk(vtot, vact));
    cyc(0, 0, 0, 1, 4, pk(vbe, vbs));
    cyc(0, 0, 0, 1, 5, pk(vse, vss));
    cyc(0, 0, 0, 1, 6, pk(srcw, srch));
    cyc(0, 0, 0, 0, 0, 0);
    // R1 / R10: words read back as written while stopped
    rd(0, pk(htot, hact), "R1 htim readback");
    rd(1, pk(hbe, hbs),   "R1 hblk readback");
    rd(2, pk(hse, hss),   "R1 hsyn readback");
    rd(3, pk(vtot, vact), "R1 vtim readback");
    rd(4, pk(vbe, vbs),   "R1 vblk readback");
    rd(5, pk(vse, vss),   "R1 vsyn readback");
    rd(6, pk(srcw, srch), "R1 src readback");
  endtask

  task automatic start_pipe();
    cyc(0, 0, 0, 1, 7, 32'h8000_0000);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R8 one edge latency", pipe_running, 0);
    rd(7, 32'h8000_0000, "R7 enable readback");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog R2 act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int fa, fb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    for (int a = 0; a < 8; a++) rd(a, 32'h0, "R11 reset register");
    outs(0, 0);

    // configuration A: 6 active of 10, 4 active lines of 7
    load_cfg(5, 9, 5, 9, 6, 8, 3, 6, 3, 6, 4, 5, 4, 2);
    fa = 10 * 7;

    // R7: status bit is read-only
    cyc(0, 0, 0, 1, 7, 32'h4000_0000);
    cyc(0, 0, 0, 0, 0, 0);
    rd(7, 32'h0, "R7 status not writable");
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 status write no start", pipe_running, 0);

    start_pipe();
    for (int t = 0; t < 2 * fa + 4; t++) begin
      bit w; int ad; logic [31:0] dv;
      w = 0; ad = 0; dv = 0;
      if (t == 5)      begin w = 1; ad = 0; dv = 32'h0003_0002; end
      if (t == fa + 5) begin w = 1; ad = 7; dv = 32'h0; end
      if (t == fa + 8) begin w = 1; ad = 5; dv = 32'h0001_0001; end
      cyc(1, (t < 2 * fa), t, w, ad, dv);
      if (t == 10)     rd(7, 32'hC000_0000, "R7 enable and status");
      if (t == fa + 7) rd(7, 32'h4000_0000, "R9 draining status");
    end
    // R10: writes made while live were dropped
    rd(0, pk(9, 5), "R10 htim locked while enabled");
    rd(5, pk(5, 4), "R10 vsyn locked while draining");

    // configuration B: border (blank starts after active), zero-width vsync
    load_cfg(7, 11, 8, 11, 9, 10, 2, 4, 3, 4, 3, 3, 5, 1);
    fb = 12 * 5;
    start_pipe();
    for (int t = 0; t < fb + 4; t++) begin
      if (t == 3) cyc(1, 1'b1, t, 1, 7, 32'h0);
      else        cyc(1, (t < fb), t, 0, 0, 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule